// File: doc/BRIEF.md
# Rippled Unsigned Magnitude Comparator

This block compares two unsigned operands of a configurable width and raises exactly one of three flags: greater, equal or less. It is a purely combinational path with no clock. Inside, a row of identical one-bit stages is chained from the least significant bit toward the most significant bit. Each stage receives the relation that the lower bits have settled on so far. When its own pair of bits differs, it overrides that relation. When its pair matches, it passes the relation through unchanged. The first stage is fed the relation "equal", so two identical operands come out as equal.

The relation that leaves the top stage drives the three output flags. A build-time option makes the less flag the NOR of the greater and equal flags, in place of the chain's own less signal. Either choice gives the same result at the ports. A design uses this comparator where a compact, regular structure is worth more than a short path: the delay grows by one stage for each bit of width.

Top module: `mag_compare_ripple`

## Requirements
- R1: For every operand pair, exactly one of `gt`, `eq`, `lt` is 1 and the other two are 0.
- R2: `eq` is 1 exactly when every bit of `a` equals the matching bit of `b`.
- R3: `gt` is 1 exactly when `a` is larger than `b` read as unsigned binary numbers, where bit WIDTH-1 carries the most weight.
- R4: `lt` is 1 exactly when `a` is smaller than `b` read as unsigned binary numbers.
- R5: A difference in a lower bit decides the outcome only when all higher bits are equal. A difference in a higher bit decides it whatever the lower bits hold.
- R6: With `LT_FROM_NOR` set to 1, the three flags are identical, for every input, to those of the default build.
- R7: The block is correct for every width from 1 upward, including a width of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| gt | output | 1 | High when a > b |
| eq | output | 1 | High when a == b |
| lt | output | 1 | High when a < b |

## Verification
The block has no clock, so no two of its functions share a cycle. The interaction that matters happens within a single evaluation: a difference in the top bit and a difference in a lower bit, pointing the opposite way, present in the same operand pair. The bench provokes this with directed pairs such as 0x8000 against 0x7FFF, and with every pair of a 4-bit build. It judges the outcome against the unsigned relational operators and checks that the three flags stay one-hot.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  // Relation carried between chained stages.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  // Relation fed into the least significant stage.
  localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mcmp_cell.sv
module mcmp_cell
  import mcmp_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  rel_t from_low,
  output rel_t to_high
);

  logic same;
  logic a_wins;
  logic b_wins;

  always_comb begin
    same         = ~(a_bit ^ b_bit);
    a_wins       = a_bit & ~b_bit;
    b_wins       = ~a_bit & b_bit;
    to_high.gt   = a_wins | (same & from_low.gt);
    to_high.eq   = same & from_low.eq;
    to_high.lt   = b_wins | (same & from_low.lt);
  end

  // Stage-level checks
  always_comb begin
    if ($onehot(from_low)) begin
      p_onehot_keep_r1: assert ($onehot(to_high))
        else $error("stage lost one-hot relation");
    end
    if (a_bit != b_bit) begin
      p_diff_decides_r5: assert (to_high.gt == a_bit && to_high.lt == b_bit && !to_high.eq)
        else $error("differing bits did not decide");
    end
    if (a_bit == b_bit) begin
      p_same_passes_r2: assert (to_high == from_low)
        else $error("matching bits altered relation");
    end
  end

endmodule

// File: rtl/mcmp_chain.sv
module mcmp_chain
  import mcmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output rel_t             result
);

  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    rel_t down;
    rel_t up;
    if (i == 0) begin : g_seed
      assign down = REL_SEED;
    end else begin : g_link
      assign down = g_stage[i-1].up;
    end
    mcmp_cell u_cell (
      .a_bit    (a[i]),
      .b_bit    (b[i]),
      .from_low (down),
      .to_high  (up)
    );
  end

  assign result = g_stage[TOP].up;

endmodule

// File: rtl/mag_compare_ripple.sv
module mag_compare_ripple
  import mcmp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit LT_FROM_NOR = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             gt,
  output logic             eq,
  output logic             lt
);

  rel_t final_rel;

  mcmp_chain #(.WIDTH(WIDTH)) u_chain (
    .a      (a),
    .b      (b),
    .result (final_rel)
  );

  assign gt = final_rel.gt;
  assign eq = final_rel.eq;

  if (LT_FROM_NOR) begin : g_lt_nor
    assign lt = ~(final_rel.gt | final_rel.eq);
  end else begin : g_lt_chain
    assign lt = final_rel.lt;
  end

  // Output-level checks
  always_comb begin
    p_out_onehot_r1: assert ($onehot({gt, eq, lt}))
      else $error("outputs not one-hot");
    p_lt_agree_r6: assert (final_rel.lt == ~(final_rel.gt | final_rel.eq))
      else $error("chain less flag disagrees with NOR form");
  end

endmodule

// File: tb/tb_mag_compare_ripple.sv
module tb_mag_compare_ripple;

  localparam int W  = 16;
  localparam int W4 = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]  a16, b16;
  logic [W4-1:0] a4, b4;
  logic          a1, b1;
  logic gt16, eq16, lt16, gt4c, eq4c, lt4c, gt4n, eq4n, lt4n, gt1, eq1, lt1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mag_compare_ripple #(.WIDTH(W)) dut (
    .a(a16), .b(b16), .gt(gt16), .eq(eq16), .lt(lt16));
  mag_compare_ripple #(.WIDTH(W4), .LT_FROM_NOR(1'b0)) dut_c4 (
    .a(a4), .b(b4), .gt(gt4c), .eq(eq4c), .lt(lt4c));
  mag_compare_ripple #(.WIDTH(W4), .LT_FROM_NOR(1'b1)) dut_n4 (
    .a(a4), .b(b4), .gt(gt4n), .eq(eq4n), .lt(lt4n));
  mag_compare_ripple #(.WIDTH(1)) dut_w1 (
    .a(a1), .b(b1), .gt(gt1), .eq(eq1), .lt(lt1));

  // {a, b} directed pairs, 16 bits each
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000},
    {16'hFFFF, 16'hFFFF},
    {16'h8000, 16'h7FFF},
    {16'h7FFF, 16'h8000},
    {16'h0001, 16'h0000},
    {16'h0000, 16'h0001},
    {16'h1235, 16'h1234},
    {16'hA5A4, 16'hA5A5},
    {16'h4000, 16'h3FFF},
    {16'hFFFE, 16'hFFFF}
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {gt,eq,lt}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] rel16(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x > y, x == y, x < y};
  endfunction

  task automatic run16(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2:0] e;
    @(negedge clk);
    a16 = x; b16 = y;
    @(posedge clk); @(negedge clk);
    e = rel16(x, y);
    if (e[2])      check("R3 greater", {gt16, eq16, lt16}, e);
    else if (e[1]) check("R2 equal",   {gt16, eq16, lt16}, e);
    else           check("R4 less",    {gt16, eq16, lt16}, e);
    check("R1 one-hot", {2'b00, $onehot({gt16, eq16, lt16})}, 3'b001);
  endtask

  initial begin
    a16 = '0; b16 = '0; a4 = '0; b4 = '0; a1 = 1'b0; b1 = 1'b0;

    // Table walk: high-bit versus low-bit conflicts (R5)
    for (int i = 0; i < NVEC; i++) begin
      run16(VEC[i][31:16], VEC[i][15:0]);
      if (VEC[i][31:16] != VEC[i][15:0])
        check("R5 top differing bit decides",
              {gt16, eq16, lt16}, rel16(VEC[i][31:16], VEC[i][15:0]));
    end

    // Random 16-bit pairs, half with shared upper byte
    for (int i = 0; i < 1000; i++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      if (i[0]) y[15:8] = x[15:8];
      run16(x, y);
    end

    // Exhaustive 4-bit, both less-flag builds (R6)
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [2:0] e;
        @(negedge clk);
        a4 = W4'(i); b4 = W4'(j);
        @(posedge clk); @(negedge clk);
        e = {i > j, i == j, i < j};
        check("R5 exhaustive 4-bit", {gt4c, eq4c, lt4c}, e);
        check("R6 NOR variant matches", {gt4n, eq4n, lt4n}, {gt4c, eq4c, lt4c});
      end
    end

    // Width of one (R7)
    for (int i = 0; i < 4; i++) begin
      logic [2:0] e;
      @(negedge clk);
      a1 = i[1]; b1 = i[0];
      @(posedge clk); @(negedge clk);
      e = {i[1] & ~i[0], i[1] == i[0], ~i[1] & i[0]};
      check("R7 width one", {gt1, eq1, lt1}, e);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule